// File: doc/BRIEF.md
# Floating-Point Subtract Special-Case Resolver

This combinational block sits in front of the mantissa datapath of a double-precision subtractor that computes x minus y. Each operand arrives already classified, as a one-hot class vector, alongside its raw 64-bit encoding. The block also receives the current rounding mode. For every one of the 36 possible class pairings it either produces the final answer itself or hands the pair on to the arithmetic datapath.

When it answers, it may raise an invalid-operation flag. Pairings with a NaN, an infinity or a zero are all settled here. When it hands a pair on, it also tells the datapath which operands are denormal and need to be normalized first.

The rounding mode only matters when both operands are zeros of the same sign. In that case it decides the sign of the zero result.

Top module: `fpsub_special_resolve`

## Requirements
- R1: Class vector bit positions are: bit 0 zero, bit 1 normal, bit 2 denormal, bit 3 infinity, bit 4 quiet NaN, bit 5 signaling NaN. The sign of each operand is bit 63 of its value.
- R2: If either operand is a signaling NaN, `invalid` and `res_valid` are 1 and `res` is the indefinite NaN 64'h7FF8_0000_0000_0000.
- R3: With no signaling NaN present, a quiet-NaN y yields `res` = y unchanged, and `invalid` is 0.
- R4: With no signaling NaN present and y not a NaN, a quiet-NaN x yields `res` = x unchanged.
- R5: Infinity minus infinity with equal signs gives `invalid` = 1 and the indefinite NaN. With opposite signs it gives x.
- R6: A finite x (zero, normal or denormal) minus an infinite y gives an infinity whose sign is the inverse of y's sign: exponent all ones, fraction zero.
- R7: An infinite x minus a finite y gives x.
- R8: Zero minus zero with different signs gives x. With equal signs it gives a zero whose sign is 1 only when `rmode` is 2'b11 (toward negative infinity). The other encodings are 2'b00 nearest, 2'b01 toward zero and 2'b10 toward positive infinity.
- R9: A nonzero finite x minus a zero gives x. A zero minus a nonzero finite y gives y with bit 63 inverted.
- R10: For pairs of nonzero finite operands, `to_datapath` is 1, `res_valid` is 0 and `res` is 0. In every other case `res_valid` is 1 and `to_datapath` is 0.
- R11: `prenorm_x` and `prenorm_y` are 1 exactly when `to_datapath` is 1 and the corresponding operand is denormal. This covers x only, y only, or both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_val | input | 64 | Minuend encoding |
| y_val | input | 64 | Subtrahend encoding |
| x_cls | input | 6 | One-hot class of x |
| y_cls | input | 6 | One-hot class of y |
| rmode | input | 2 | Rounding mode |
| res | output | 64 | Resolved result, zero when routed on |
| res_valid | output | 1 | Result is final |
| invalid | output | 1 | Invalid-operation exception |
| to_datapath | output | 1 | Pair needs mantissa arithmetic |
| prenorm_x | output | 1 | x must be normalized before arithmetic |
| prenorm_y | output | 1 | y must be normalized before arithmetic |

## Verification
The sweep covers all 36 class pairings, each under all four sign combinations and all four rounding modes. It therefore separates the NaN priority order (signaling over quiet, y's quiet NaN over x's) from the infinity and zero rules. The sign sweep tells apart the equal-sign and opposite-sign branches of infinity minus infinity and of zero minus zero. The rounding-mode sweep shows that only the equal-sign zero case reacts to the mode. The NaN operands carry distinct payloads, so a returned NaN can be traced to the operand it came from. The normal and denormal operands carry distinct fractions, so a flipped-sign pass-through of y can be told apart from a pass-through of x.

// File: rtl/fpsub_pkg.sv
package fpsub_pkg;

  // one-hot class bit positions
  localparam int CB_ZERO  = 0;
  localparam int CB_NORM  = 1;
  localparam int CB_DNORM = 2;
  localparam int CB_INF   = 3;
  localparam int CB_QNAN  = 4;
  localparam int CB_SNAN  = 5;
  localparam int CLS_W    = 6;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } rmode_e;

  // what the resolver decided for a pair
  typedef enum logic [3:0] {
    V_INDEF,       // invalid, return default NaN
    V_PASS_Y,      // return y unchanged
    V_PASS_X,      // return x unchanged
    V_INF_NEG_Y,   // infinity with sign of y inverted
    V_ZERO_RM,     // signed zero chosen by rounding mode
    V_NEG_Y,       // y with sign bit inverted
    V_DATAPATH     // arithmetic needed
  } verdict_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic norm;
    logic dnorm;
    logic inf;
    logic qnan;
    logic snan;
    logic nan;
    logic finite;
    logic nz_finite;
  } opsum_t;

endpackage

// File: rtl/fpsub_opnd_summary.sv
module fpsub_opnd_summary
  import fpsub_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0]     val,
  input  logic [CLS_W-1:0] cls,
  output opsum_t           sum
);

  always_comb begin
    sum           = '0;
    sum.sign      = val[W-1];
    sum.zero      = cls[CB_ZERO];
    sum.norm      = cls[CB_NORM];
    sum.dnorm     = cls[CB_DNORM];
    sum.inf       = cls[CB_INF];
    sum.qnan      = cls[CB_QNAN];
    sum.snan      = cls[CB_SNAN];
    sum.nan       = cls[CB_QNAN] | cls[CB_SNAN];
    sum.finite    = ~(cls[CB_INF] | cls[CB_QNAN] | cls[CB_SNAN]);
    sum.nz_finite = sum.finite & ~cls[CB_ZERO];
  end

endmodule

// File: rtl/fpsub_case_select.sv
module fpsub_case_select
  import fpsub_pkg::*;
(
  input  opsum_t   xs,
  input  opsum_t   ys,
  output verdict_e verdict,
  output logic     signs_equal
);

  // priority-ordered decision over class pairs
  function automatic verdict_e decide(input opsum_t a, input opsum_t b);
    verdict_e v;
    logic same;
    same = (a.sign == b.sign);
    if (a.snan || b.snan)            v = V_INDEF;
    else if (b.qnan)                 v = V_PASS_Y;
    else if (a.qnan)                 v = V_PASS_X;
    else if (a.inf && b.inf)         v = same ? V_INDEF : V_PASS_X;
    else if (b.inf)                  v = V_INF_NEG_Y;
    else if (a.inf)                  v = V_PASS_X;
    else if (a.zero && b.zero)       v = same ? V_ZERO_RM : V_PASS_X;
    else if (b.zero)                 v = V_PASS_X;
    else if (a.zero)                 v = V_NEG_Y;
    else                             v = V_DATAPATH;
    return v;
  endfunction

  assign verdict     = decide(xs, ys);
  assign signs_equal = (xs.sign == ys.sign);

endmodule

// File: rtl/fpsub_result_build.sv
module fpsub_result_build
  import fpsub_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  verdict_e                    verdict,
  input  logic [EXP_W+FRAC_W:0]       x_val,
  input  logic [EXP_W+FRAC_W:0]       y_val,
  input  logic [1:0]                  rmode,
  output logic [EXP_W+FRAC_W:0]       res,
  output logic                        res_valid,
  output logic                        invalid
);

  localparam int W = EXP_W + FRAC_W + 1;

  function automatic logic [W-1:0] make_inf(input logic s);
    return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction

  function automatic logic [W-1:0] make_zero(input logic s);
    return {s, {(W-1){1'b0}}};
  endfunction

  function automatic logic [W-1:0] make_indef();
    return {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  endfunction

  always_comb begin
    res       = '0;
    res_valid = 1'b1;
    invalid   = 1'b0;
    unique case (verdict)
      V_INDEF: begin
        res     = make_indef();
        invalid = 1'b1;
      end
      V_PASS_Y:    res = y_val;
      V_PASS_X:    res = x_val;
      V_INF_NEG_Y: res = make_inf(~y_val[W-1]);
      V_ZERO_RM:   res = make_zero(rmode == RM_DOWN);
      V_NEG_Y:     res = {~y_val[W-1], y_val[W-2:0]};
      default:     res_valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/fpsub_special_resolve.sv
module fpsub_special_resolve
  import fpsub_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = EXP_W + FRAC_W + 1
) (
  input  logic [W-1:0]     x_val,
  input  logic [W-1:0]     y_val,
  input  logic [CLS_W-1:0] x_cls,
  input  logic [CLS_W-1:0] y_cls,
  input  logic [1:0]       rmode,
  output logic [W-1:0]     res,
  output logic             res_valid,
  output logic             invalid,
  output logic             to_datapath,
  output logic             prenorm_x,
  output logic             prenorm_y
);

  opsum_t   sums [2];
  verdict_e verdict;
  logic     signs_equal;
  logic     any_snan;
  logic     need_arith;

  logic [W-1:0]     vals [2];
  logic [CLS_W-1:0] clss [2];
  assign vals[0] = x_val;
  assign vals[1] = y_val;
  assign clss[0] = x_cls;
  assign clss[1] = y_cls;

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    fpsub_opnd_summary #(.W(W)) u_sum (
      .val (vals[g]),
      .cls (clss[g]),
      .sum (sums[g])
    );
  end

  fpsub_case_select u_sel (
    .xs          (sums[0]),
    .ys          (sums[1]),
    .verdict     (verdict),
    .signs_equal (signs_equal)
  );

  fpsub_result_build #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_build (
    .verdict   (verdict),
    .x_val     (x_val),
    .y_val     (y_val),
    .rmode     (rmode),
    .res       (res),
    .res_valid (res_valid),
    .invalid   (invalid)
  );

  // named internal events
  assign any_snan    = sums[0].snan | sums[1].snan;
  assign need_arith  = (verdict == V_DATAPATH);
  assign to_datapath = need_arith;
  assign prenorm_x   = need_arith & sums[0].dnorm;
  assign prenorm_y   = need_arith & sums[1].dnorm;

endmodule

// File: rtl/fpsub_special_resolve_chk.sv
module fpsub_special_resolve_chk
  import fpsub_pkg::*;
#(
  parameter int W = 64
) (
  input logic [W-1:0]     res,
  input logic             res_valid,
  input logic             invalid,
  input logic             to_datapath,
  input logic             prenorm_x,
  input logic             prenorm_y,
  input logic [CLS_W-1:0] x_cls,
  input logic [CLS_W-1:0] y_cls
);

  localparam logic [W-1:0] INDEF = {1'b0, {11{1'b1}}, 1'b1, {(W-13){1'b0}}};

  always_comb begin
    p_one_outcome_r10: assert (res_valid != to_datapath);
    p_snan_flags_r2: assert (!(x_cls[CB_SNAN] || y_cls[CB_SNAN]) || invalid);
    p_invalid_indef_r5: assert (!invalid || (res_valid && res == INDEF));
    p_prenorm_gate_r11: assert (to_datapath || !(prenorm_x || prenorm_y));
    p_special_never_routed_r10: assert (!to_datapath ||
      ((x_cls | y_cls) & ((1 << CB_ZERO) | (1 << CB_INF) | (1 << CB_QNAN) | (1 << CB_SNAN))) == '0);
  end

endmodule

bind fpsub_special_resolve fpsub_special_resolve_chk #(.W(W)) u_chk (
  .res         (res),
  .res_valid   (res_valid),
  .invalid     (invalid),
  .to_datapath (to_datapath),
  .prenorm_x   (prenorm_x),
  .prenorm_y   (prenorm_y),
  .x_cls       (x_cls),
  .y_cls       (y_cls)
);

// File: tb/fpsub_special_resolve_bench.sv
module fpsub_special_resolve_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] INDEF = 64'h7FF8_0000_0000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] x_val, y_val, res;
  logic [5:0]  x_cls, y_cls;
  logic [1:0]  rmode;
  logic res_valid, invalid, to_datapath, prenorm_x, prenorm_y;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  fpsub_special_resolve u_fpsub_special_resolve (
    .x_val(x_val), .y_val(y_val), .x_cls(x_cls), .y_cls(y_cls), .rmode(rmode),
    .res(res), .res_valid(res_valid), .invalid(invalid),
    .to_datapath(to_datapath), .prenorm_x(prenorm_x), .prenorm_y(prenorm_y)
  );

  // class index: 0 zero 1 norm 2 dnorm 3 inf 4 qnan 5 snan (R1)
  function automatic logic [63:0] make_opnd(input int c, input logic s, input logic is_y);
    logic [51:0] f;
    f = is_y ? 52'h0_1234_5678_9ABC : 52'h5_0F0F_0F0F_0F0F;
    case (c)
      0: return {s, 63'd0};
      1: return {s, is_y ? 11'h401 : 11'h3FE, f};
      2: return {s, 11'h000, f};
      3: return {s, 11'h7FF, 52'd0};
      4: return {s, 11'h7FF, 1'b1, f[50:0]};
      default: return {s, 11'h7FF, 1'b0, f[50:0] | 51'd1};
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] er, input logic ev,
                       input logic ei, input logic ed, input logic epx, input logic epy);
    n_vec++;
    if (res !== er || res_valid !== ev || invalid !== ei || to_datapath !== ed ||
        prenorm_x !== epx || prenorm_y !== epy) begin
      n_bad++;
      $display("FAIL %s xc=%b yc=%b rm=%0d: got res=%h v=%b i=%b d=%b px=%b py=%b exp res=%h v=%b i=%b d=%b px=%b py=%b",
               tag, x_cls, y_cls, rmode, res, res_valid, invalid, to_datapath, prenorm_x, prenorm_y,
               er, ev, ei, ed, epx, epy);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    x_val = '0; y_val = '0; x_cls = 6'b000010; y_cls = 6'b000010; rmode = 2'b00;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // initial state: normal minus normal is routed on (R10)
    check("R10 initial", 64'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

    for (int xc = 0; xc < 6; xc++)
      for (int yc = 0; yc < 6; yc++)
        for (int sg = 0; sg < 4; sg++)
          for (int rm = 0; rm < 4; rm++) begin
            logic xs, ys;
            logic [63:0] xv, yv, er;
            logic ev, ei, ed, epx, epy;
            string tag;
            xs = sg[0]; ys = sg[1];
            xv = make_opnd(xc, xs, 1'b0);
            yv = make_opnd(yc, ys, 1'b1);
            ev = 1'b1; ei = 1'b0; ed = 1'b0; epx = 1'b0; epy = 1'b0; er = 64'd0;
            if (xc == 5 || yc == 5) begin
              tag = "R2 snan"; er = INDEF; ei = 1'b1;
            end else if (yc == 4) begin
              tag = "R3 qnan y"; er = yv;
            end else if (xc == 4) begin
              tag = "R4 qnan x"; er = xv;
            end else if (xc == 3 && yc == 3) begin
              tag = "R5 inf-inf";
              if (xs == ys) begin er = INDEF; ei = 1'b1; end else er = xv;
            end else if (yc == 3) begin
              tag = "R6 fin-inf"; er = {~ys, 11'h7FF, 52'd0};
            end else if (xc == 3) begin
              tag = "R7 inf-fin"; er = xv;
            end else if (xc == 0 && yc == 0) begin
              tag = "R8 zero-zero";
              er = (xs != ys) ? xv : {(rm == 3), 63'd0};
            end else if (yc == 0) begin
              tag = "R9 x-zero"; er = xv;
            end else if (xc == 0) begin
              tag = "R9 zero-y"; er = yv ^ (64'd1 << 63);
            end else begin
              tag = "R11 R10 datapath"; ev = 1'b0; ed = 1'b1;
              epx = (xc == 2); epy = (yc == 2);
            end
            @(posedge clk);
            x_val = xv; y_val = yv;
            x_cls = 6'(1 << xc); y_cls = 6'(1 << yc);
            rmode = 2'(rm);
            @(negedge clk);
            check(tag, er, ev, ei, ed, epx, epy);
          end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule